// File: doc/BRIEF.md
# Burst Next-Address Predictor

This block sits on the target side of a bus that uses registered-feedback burst cycles. It watches each transfer and works out the word address of the transfer that will follow. The inputs are the cycle-type tag, the burst-type extension, the present word address, the cycle and strobe qualifiers, and the target's acknowledge. A target can use the predicted address to start a read for the next beat early, before the initiator presents that address.

A transfer counts only on a clock edge where cycle, strobe and acknowledge are all high. On each such edge the block registers a new predicted address and updates a flag that shows whether the burst goes on. An incrementing burst steps the address in one of two ways. A linear burst steps the whole address. A wrapping burst of 4, 8 or 16 words steps only the low word-address bits and holds the bits above them. A constant-address burst repeats the present address. A classic cycle, an end-of-burst transfer, or a dropped cycle ends the prediction.

Top module: `wb_burst_predictor`

## Requirements
- R1: While reset (`rst_n` low) is active, and on the first cycle after it, `next_adr` is 0 and `burst_on` is 0.
- R2: On any edge where `cyc_i & stb_i & ack_i` is 0, `next_adr` keeps its value. This covers a stalled beat (no acknowledge) and an acknowledge that arrives without strobe.
- R3: An acknowledged beat with cycle type 3'b010 (incrementing) and extension 2'b00 (linear) sets `next_adr` to `adr_i + 1`, modulo 2^ADDR_W.
- R4: An acknowledged incrementing beat with extension 2'b01, 2'b10 or 2'b11 increments only the low 2, 3 or 4 bits of `adr_i`, with wrap-around. All higher bits are copied unchanged.
- R5: An acknowledged beat with cycle type 3'b001 (constant address) sets `next_adr` to `adr_i`, whatever the extension is.
- R6: An acknowledged beat with cycle type 3'b000 (classic), or with any of the unused codes 3'b011 to 3'b110, sets `next_adr` to `adr_i` and clears `burst_on`.
- R7: An acknowledged beat with cycle type 3'b111 (end of burst) sets `next_adr` to `adr_i` and clears `burst_on`.
- R8: An edge with `cyc_i` low clears `burst_on` and leaves `next_adr` unchanged.
- R9: An acknowledged beat with cycle type 3'b001 or 3'b010 sets `burst_on`. Without an acknowledge, `burst_on` keeps its value while `cyc_i` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Transfer strobe |
| ack_i | input | 1 | Target acknowledge |
| cti_i | input | 3 | Cycle-type tag |
| bte_i | input | 2 | Burst-type extension |
| adr_i | input | ADDR_W | Word address of the current transfer |
| next_adr | output | ADDR_W | Predicted address of the next transfer |
| burst_on | output | 1 | A burst is still in progress |

## Verification
The assertions assume that the cycle-type and extension inputs are defined whenever a beat is acknowledged. They also assume that reset is held for at least one edge before any traffic. The stimulus changes every input on the falling clock edge, so all inputs are stable at the rising edge. It also holds reset low for several cycles before the first transfer. The stimulus walks bursts across wrap boundaries and across the top of the address space, inserts stalls and strobe-less acknowledges, and drops the cycle in the middle of a burst.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
  localparam logic [2:0] CT_CLASSIC = 3'b000;
  localparam logic [2:0] CT_CONST   = 3'b001;
  localparam logic [2:0] CT_INCR    = 3'b010;
  localparam logic [2:0] CT_LAST    = 3'b111;

  localparam logic [1:0] BX_LINEAR = 2'b00;
  localparam logic [1:0] BX_WRAP4  = 2'b01;
  localparam logic [1:0] BX_WRAP8  = 2'b10;
  localparam logic [1:0] BX_WRAP16 = 2'b11;

  typedef enum logic [1:0] {
    BK_SINGLE = 2'd0,
    BK_HOLD   = 2'd1,
    BK_STEP   = 2'd2,
    BK_FINAL  = 2'd3
  } beat_kind_t;
endpackage

// File: rtl/wbp_kind_decode.sv
module wbp_kind_decode
  import wbp_pkg::*;
(
  input  logic [2:0]  cti,
  output beat_kind_t  kind
);
  always_comb begin
    case (cti)
      CT_CONST: kind = BK_HOLD;
      CT_INCR:  kind = BK_STEP;
      CT_LAST:  kind = BK_FINAL;
      default:  kind = BK_SINGLE;
    endcase
  end
endmodule

// File: rtl/wbp_step.sv
module wbp_step
  import wbp_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] adr,
  input  logic [1:0]        bte,
  output logic [ADDR_W-1:0] stepped
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  function automatic logic [ADDR_W-1:0] step_fn(input logic [ADDR_W-1:0] a,
                                                input logic [1:0] x);
    logic [ADDR_W-1:0] r;
    r = a;
    case (x)
      BX_LINEAR: r = a + ONE;
      BX_WRAP4:  r[1:0] = a[1:0] + 2'd1;
      BX_WRAP8:  r[2:0] = a[2:0] + 3'd1;
      default:   r[3:0] = a[3:0] + 4'd1;
    endcase
    return r;
  endfunction

  assign stepped = step_fn(adr, bte);
endmodule

// File: rtl/wb_burst_predictor.sv
module wb_burst_predictor
  import wbp_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              ack_i,
  input  logic [2:0]        cti_i,
  input  logic [1:0]        bte_i,
  input  logic [ADDR_W-1:0] adr_i,
  output logic [ADDR_W-1:0] next_adr,
  output logic              burst_on
);
  beat_kind_t        kind;
  logic [ADDR_W-1:0] stepped;
  logic              beat_w;
  logic              keeps_going_w;

  wbp_kind_decode u_dec (.cti(cti_i), .kind(kind));
  wbp_step #(.ADDR_W(ADDR_W)) u_step (.adr(adr_i), .bte(bte_i), .stepped(stepped));

  assign beat_w        = cyc_i & stb_i & ack_i;
  assign keeps_going_w = (kind == BK_STEP) || (kind == BK_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_adr <= '0;
      burst_on <= 1'b0;
    end else if (beat_w) begin
      next_adr <= (kind == BK_STEP) ? stepped : adr_i;
      burst_on <= keeps_going_w;
    end else if (!cyc_i) begin
      burst_on <= 1'b0;
    end
  end

  // Assertions
  assert_hold_no_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cyc_i & stb_i & ack_i) |=> $stable(next_adr));

  assert_linear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_i & stb_i & ack_i && cti_i == 3'b010 && bte_i == 2'b00)
      |=> next_adr == $past(adr_i) + ADDR_W'(1));

  generate
    if (ADDR_W > 4) begin : g_wrap_chk
      assert_wrap_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_i & stb_i & ack_i && cti_i == 3'b010 && bte_i != 2'b00)
          |=> next_adr[ADDR_W-1:4] == $past(adr_i[ADDR_W-1:4]));
    end
  endgenerate

  assert_const_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_i & stb_i & ack_i && cti_i == 3'b001) |=> (next_adr == $past(adr_i)) && burst_on);

  assert_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_i & stb_i & ack_i && cti_i == 3'b111) |=> !burst_on);

  assert_cyc_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_i |=> !burst_on);
endmodule

// File: tb/tb_wb_burst_predictor.sv
module tb_wb_burst_predictor;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_i = 0, stb_i = 0, ack_i = 0;
  logic [2:0] cti_i = 0;
  logic [1:0] bte_i = 0;
  logic [AW-1:0] adr_i = 0;
  logic [AW-1:0] next_adr;
  logic burst_on;

  always #10 clk = ~clk;

  wb_burst_predictor #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cyc_i(cyc_i), .stb_i(stb_i), .ack_i(ack_i),
    .cti_i(cti_i), .bte_i(bte_i), .adr_i(adr_i),
    .next_adr(next_adr), .burst_on(burst_on));

  typedef struct {
    logic [AW-1:0] adr;
    logic          act;
    string         tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  logic [AW-1:0] m_adr = 0;
  logic m_act = 0;
  logic done = 0;

  function automatic logic [AW-1:0] mdl_next(input logic [AW-1:0] a, input logic [1:0] x);
    logic [AW-1:0] m;
    if (x == 2'b00) return a + AW'(1);
    m = AW'((1 << (int'(x) + 1)) - 1);
    return (a & ~m) | ((a + AW'(1)) & m);
  endfunction

  task automatic drive(input logic c, input logic s, input logic k, input logic [2:0] t,
                       input logic [1:0] x, input logic [AW-1:0] a, input string tag);
    exp_t e;
    @(negedge clk);
    cyc_i = c; stb_i = s; ack_i = k; cti_i = t; bte_i = x; adr_i = a;
    if (c && s && k) begin
      if (t == 3'b010) begin m_adr = mdl_next(a, x); m_act = 1; end
      else if (t == 3'b001) begin m_adr = a; m_act = 1; end
      else begin m_adr = a; m_act = 0; end
    end else if (!c) m_act = 0;
    e.adr = m_adr; e.act = m_act; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic check(input logic [AW-1:0] ga, input logic gb, input exp_t e);
    n_cmp++;
    if (ga !== e.adr || gb !== e.act) begin
      n_bad++;
      $display("FAIL %s: got adr=%h act=%b expected adr=%h act=%b", e.tag, ga, gb, e.adr, e.act);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) check(next_adr, burst_on, q.pop_front());
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    exp_t r;
    repeat (4) @(posedge clk);
    #1;
    r.adr = '0; r.act = 0; r.tag = "R1 in reset";
    check(next_adr, burst_on, r);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    r.tag = "R1 after reset";
    check(next_adr, burst_on, r);

    // R3 linear, across a carry and across the top of the space
    drive(1,1,1,3'b010,2'b00,12'h0FE,"R3 linear");
    drive(1,1,1,3'b010,2'b00,12'h0FF,"R3 linear carry");
    drive(1,1,0,3'b010,2'b00,12'h100,"R2 stall");
    drive(1,1,1,3'b010,2'b00,12'h100,"R9 active");
    drive(1,1,1,3'b010,2'b00,12'hFFF,"R3 wrap top");
    drive(1,1,1,3'b111,2'b00,12'h000,"R7 end");
    drive(1,0,1,3'b010,2'b00,12'h555,"R2 ack no stb");
    // R4 wraps
    for (int i = 0; i < 4; i++)
      drive(1,1,1,3'b010,2'b01,12'h104 | AW'((1 + i) % 4),"R4 wrap4");
    for (int i = 0; i < 8; i++)
      drive(1,1,1,3'b010,2'b10,12'h238 | AW'((6 + i) % 8),"R4 wrap8");
    for (int i = 0; i < 16; i++)
      drive(1,1,1,3'b010,2'b11,12'h3F0 | AW'((13 + i) % 16),"R4 wrap16");
    drive(1,1,1,3'b111,2'b11,12'h3FC,"R7 end wrap");
    // R5 constant
    drive(1,1,1,3'b001,2'b10,12'h7A7,"R5 const");
    drive(1,1,1,3'b001,2'b00,12'h7A7,"R5 const again");
    drive(1,1,0,3'b000,2'b00,12'h7A7,"R9 hold no ack");
    // R8 cyc drop
    drive(0,1,1,3'b010,2'b00,12'h123,"R8 cyc low");
    drive(1,1,1,3'b010,2'b00,12'h200,"R9 restart");
    drive(1,1,1,3'b000,2'b00,12'h345,"R6 classic");
    drive(1,1,1,3'b010,2'b01,12'h403,"R4 wrap4 top");
    drive(1,1,1,3'b101,2'b00,12'h406,"R6 unused code");
    drive(1,1,1,3'b010,2'b10,12'h40F,"R4 wrap8 top");
    drive(1,1,1,3'b011,2'b00,12'h411,"R6 unused 3");
    drive(0,0,0,3'b000,2'b00,12'h000,"R2 idle");
    drive(0,0,0,3'b000,2'b00,12'hABC,"R2 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule